// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

This block connects a host's 8-bit register bus to 24 peripheral pins, organised as two 8-bit ports, A and B, and one 8-bit port C. The pins form two groups of twelve. The first group is port A plus the upper nibble of C. The second group is port B plus the lower nibble of C. A control write chooses each group's mode. In the simple mode the pins are plain registered outputs or sampled inputs, with direction chosen per byte for A and B and per nibble for C. In the strobed mode a port carries 8 data bits, and port C pins act as handshake and interrupt lines. The first group also has a bidirectional mode, in which port A carries traffic both ways and takes five handshake lines from port C.

Each pin is modelled as three separate signals: a driven value, an output enable and a sampled input. The block therefore contains no tristate nets. Host accesses are synchronous. A cycle with `bus_cs` and `bus_wr` high is one write. A cycle with `bus_cs` and `bus_rd` high is one read: its data appears combinationally during that cycle and its side effects take place at the closing clock edge. Peripheral strobe and acknowledge pins are sampled on `clk`, and their edges are detected one sample apart.

Both strobed directions behave as streams. For input, a falling strobe is "valid" and the input-buffer-full flag is "not ready". While the flag is set, further strobes are refused, and a host read of the port consumes the byte. For output, a host write is "valid" and drives the output-buffer-full pin low, which stays low until the peripheral acknowledges.

Top module: `ppi_top`

## Requirements
- R1: After reset, every port is in the simple mode with all 24 pins as inputs, so every output enable is 0. All output latches read as zero.
- R2: Address 0 selects port A, address 1 selects port B and address 2 selects port C. Address 3 is the control register, and a read from it returns 0x00.
- R3: A control write with bit 7 set defines the modes:
  - bits 6:5 give the first-group mode: 00 simple, 01 strobed, 1x bidirectional;
  - bit 4 is the port A direction;
  - bit 3 is the upper C nibble direction;
  - bit 2 is the second-group mode: 0 simple, 1 strobed;
  - bit 1 is the port B direction;
  - bit 0 is the lower C nibble direction.

  A direction bit of 1 means input. Every mode write clears all three output latches and all handshake state.
- R4: In the simple mode, an output port drives its latch with its enables at 0xFF, and an input port has enables of 0x00. Reading a port returns the pins where it is an input and the latch where it is an output. For port C this applies per nibble.
- R5: A control write with bit 7 clear changes only the port C latch bit selected by bits 3:1, setting it to bit 0. A write to address 2 loads the whole port C latch.
- R6: In strobed input, a falling edge on the strobe pin captures the port pins and sets the input-buffer-full flag. A later read of the port returns the captured byte.
- R7: In strobed input, a rising strobe edge while the flag is set raises the interrupt, provided the enable bit is 1. The enable bit is port C latch bit 4 for port A and bit 2 for port B. A host read of the port clears both the interrupt and the flag at the end of the read.
- R8: A falling strobe edge while input-buffer-full is set is refused. The captured byte and the flag stay as they were.
- R9: In strobed output, a host write to the port drives the byte, pulls output-buffer-full low and clears the interrupt. A falling acknowledge edge returns output-buffer-full high. A rising acknowledge edge raises the interrupt, provided the enable bit is 1: port C latch bit 6 for port A, bit 2 for port B.
- R10: The port C handshake pins are fixed:
  - bit 3 carries the first-group interrupt (driven);
  - bit 4 is the port A strobe (input);
  - bit 5 is the port A input-buffer-full flag (driven);
  - bit 6 is the port A acknowledge (input);
  - bit 7 is the port A output-buffer-full flag, active low (driven);
  - bit 0 carries the second-group interrupt (driven);
  - bit 1 carries port B's buffer flag (driven);
  - bit 2 is port B's strobe or acknowledge (input).

  Handshake inputs are never driven. Unused pins follow their nibble direction.
- R11: In the bidirectional mode, port A drives only while the acknowledge pin (C bit 6) is low. The input side follows R6 and R8. The first-group interrupt is the OR of the input and output interrupts, with enables at C latch bits 4 and 6.
- R12: A port C read in a strobed mode returns the live status at the driven handshake positions and the latch (the enable bit) at the handshake input positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is asserted |
| pa_in | input | 8 | Port A pin samples |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin samples |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin samples |
| pc_out | output | 8 | Port C driven values |
| pc_oe | output | 8 | Port C output enables |

## Verification
A wrong decode of the mode register appears on the enable vectors in the first cycle after the control write, because the enables are combinational from the stored configuration. A handshake flag that fails to set, clear or hold shows on its port C pin at the edge after the strobe, acknowledge or host access that should have changed it. A refused strobe that wrongly overwrites the buffer only appears at the next port read, so the bench reads back after every refused capture.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W = 8;

  localparam logic [1:0] ADDR_A   = 2'd0;
  localparam logic [1:0] ADDR_B   = 2'd1;
  localparam logic [1:0] ADDR_C   = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;

  // port C handshake positions
  localparam int PC_INTR_B = 0;
  localparam int PC_FLAG_B = 1;
  localparam int PC_HS_B   = 2;
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef enum logic [1:0] {
    GM_SIMPLE   = 2'd0,
    GM_STROBED  = 2'd1,
    GM_BIDIR    = 2'd2
  } gmode_e;

  typedef struct packed {
    gmode_e mode_a;
    logic   a_in;
    logic   cu_in;
    logic   mode_b;
    logic   b_in;
    logic   cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode_a: GM_SIMPLE, a_in: 1'b1, cu_in: 1'b1,
                                 mode_b: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic cfg_t decode_cfg(input logic [7:0] w);
    cfg_t c;
    c.mode_a = w[6] ? GM_BIDIR : (w[5] ? GM_STROBED : GM_SIMPLE);
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.mode_b = w[2];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction
endpackage

// File: rtl/ppi_in_hs.sv
module ppi_in_hs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         stb_n,
  input  logic         inte,
  input  logic [W-1:0] din,
  input  logic         host_rd,
  output logic         ibf,
  output logic         intr,
  output logic [W-1:0] dq
);
  logic stb_q;
  logic fall, rise;

  assign fall = stb_q & ~stb_n;
  assign rise = ~stb_q & stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b1;
      ibf   <= 1'b0;
      intr  <= 1'b0;
      dq    <= '0;
    end else begin
      stb_q <= stb_n;
      if (clr) begin
        ibf  <= 1'b0;
        intr <= 1'b0;
      end else if (en) begin
        if (fall && !ibf) begin
          dq  <= din;
          ibf <= 1'b1;
        end else if (host_rd) begin
          ibf <= 1'b0;
        end
        if (host_rd) intr <= 1'b0;
        else if (rise && inte && ibf) intr <= 1'b1;
      end
    end
  end

  // R7: a host read empties the buffer and drops the interrupt
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && host_rd && !fall |=> !ibf && !intr);

  // R8: a full buffer refuses new strobes and keeps its byte
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && ibf && !host_rd |=> ibf && $stable(dq));

  // R7: the interrupt only rises with the enable and a full buffer
  a_r7_intr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(inte && ibf));
endmodule

// File: rtl/ppi_out_hs.sv
module ppi_out_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic ack_n,
  input  logic inte,
  input  logic host_wr,
  output logic obf_n,
  output logic intr
);
  logic ack_q;
  logic fall, rise;

  assign fall = ack_q & ~ack_n;
  assign rise = ~ack_q & ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
      obf_n <= 1'b1;
      intr  <= 1'b0;
    end else begin
      ack_q <= ack_n;
      if (clr) begin
        obf_n <= 1'b1;
        intr  <= 1'b0;
      end else if (en) begin
        if (host_wr) begin
          obf_n <= 1'b0;
          intr  <= 1'b0;
        end else begin
          if (fall) obf_n <= 1'b1;
          if (rise && inte) intr <= 1'b1;
        end
      end
    end
  end

  // R9: a host write marks the buffer full and clears the interrupt
  a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && host_wr |=> !obf_n && !intr);

  // R9: a falling acknowledge empties the buffer
  a_r9_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && !host_wr && ack_q && !ack_n |=> obf_n);
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  localparam int NGRP = 2;

  cfg_t              cfg;
  logic [PORT_W-1:0] pa_lat, pb_lat, pc_lat;

  logic wr_hit, rd_hit, mode_wr, bsr_wr;
  assign wr_hit  = bus_cs & bus_wr;
  assign rd_hit  = bus_cs & bus_rd;
  assign mode_wr = wr_hit && bus_addr == ADDR_CTL && bus_wdata[7];
  assign bsr_wr  = wr_hit && bus_addr == ADDR_CTL && !bus_wdata[7];

  logic a_strobed, a_bidir;
  assign a_strobed = cfg.mode_a == GM_STROBED;
  assign a_bidir   = cfg.mode_a == GM_BIDIR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (mode_wr) begin
      cfg    <= decode_cfg(bus_wdata);
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (bsr_wr) begin
      pc_lat[bus_wdata[3:1]] <= bus_wdata[0];
    end else if (wr_hit) begin
      case (bus_addr)
        ADDR_A:  pa_lat <= bus_wdata;
        ADDR_B:  pb_lat <= bus_wdata;
        ADDR_C:  pc_lat <= bus_wdata;
        default: ;
      endcase
    end
  end

  // handshake channels, one input and one output unit per group
  logic [PORT_W-1:0] grp_din [NGRP];
  logic [PORT_W-1:0] grp_dq  [NGRP];
  logic [NGRP-1:0]   in_en, out_en, p_rd, p_wr;
  logic [NGRP-1:0]   ibf, in_intr, obf_n, out_intr;

  assign grp_din[0] = pa_in;
  assign grp_din[1] = pb_in;
  assign in_en[0]   = (a_strobed && cfg.a_in) || a_bidir;
  assign out_en[0]  = (a_strobed && !cfg.a_in) || a_bidir;
  assign in_en[1]   = cfg.mode_b && cfg.b_in;
  assign out_en[1]  = cfg.mode_b && !cfg.b_in;
  assign p_rd[0]    = rd_hit && bus_addr == ADDR_A;
  assign p_rd[1]    = rd_hit && bus_addr == ADDR_B;
  assign p_wr[0]    = wr_hit && bus_addr == ADDR_A;
  assign p_wr[1]    = wr_hit && bus_addr == ADDR_B;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int STB_POS = (g == 0) ? PC_STB_A : PC_HS_B;
    localparam int ACK_POS = (g == 0) ? PC_ACK_A : PC_HS_B;

    ppi_in_hs #(.W(PORT_W)) u_in (
      .clk(clk), .rst_n(rst_n), .en(in_en[g]), .clr(mode_wr),
      .stb_n(pc_in[STB_POS]), .inte(pc_lat[STB_POS]), .din(grp_din[g]),
      .host_rd(p_rd[g]), .ibf(ibf[g]), .intr(in_intr[g]), .dq(grp_dq[g])
    );

    ppi_out_hs u_out (
      .clk(clk), .rst_n(rst_n), .en(out_en[g]), .clr(mode_wr),
      .ack_n(pc_in[ACK_POS]), .inte(pc_lat[ACK_POS]), .host_wr(p_wr[g]),
      .obf_n(obf_n[g]), .intr(out_intr[g])
    );
  end

  // port C composition: driven handshakes, handshake inputs, general pins
  logic [PORT_W-1:0] hs_out, hs_in, stat, dir_in, pc_rd;

  always_comb begin
    hs_out = '0;
    hs_in  = '0;
    stat   = '0;
    if (a_strobed || a_bidir) begin
      hs_out[PC_INTR_A] = 1'b1;
      stat[PC_INTR_A]   = in_intr[0] | out_intr[0];
      if (in_en[0]) begin
        hs_in[PC_STB_A]  = 1'b1;
        hs_out[PC_IBF_A] = 1'b1;
        stat[PC_IBF_A]   = ibf[0];
      end
      if (out_en[0]) begin
        hs_in[PC_ACK_A]  = 1'b1;
        hs_out[PC_OBF_A] = 1'b1;
        stat[PC_OBF_A]   = obf_n[0];
      end
    end
    if (cfg.mode_b) begin
      hs_out[PC_INTR_B] = 1'b1;
      stat[PC_INTR_B]   = in_intr[1] | out_intr[1];
      hs_in[PC_HS_B]    = 1'b1;
      hs_out[PC_FLAG_B] = 1'b1;
      stat[PC_FLAG_B]   = cfg.b_in ? ibf[1] : obf_n[1];
    end
  end

  assign dir_in = {{4{cfg.cu_in}}, {4{cfg.cl_in}}};
  assign pc_oe  = hs_out | (~hs_in & ~dir_in);
  assign pc_out = (hs_out & stat) | (~hs_out & pc_lat);
  assign pc_rd  = (hs_out & stat)
                | (~hs_out & (((hs_in | ~dir_in) & pc_lat) | (~hs_in & dir_in & pc_in)));

  assign pa_out = pa_lat;
  assign pa_oe  = a_bidir ? {PORT_W{~pc_in[PC_ACK_A]}} : {PORT_W{~cfg.a_in}};
  assign pb_out = pb_lat;
  assign pb_oe  = {PORT_W{~cfg.b_in}};

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (bus_addr)
        ADDR_A:  bus_rdata = in_en[0] ? grp_dq[0]
                           : ((!a_strobed && !a_bidir && cfg.a_in) ? pa_in : pa_lat);
        ADDR_B:  bus_rdata = in_en[1] ? grp_dq[1]
                           : ((!cfg.mode_b && cfg.b_in) ? pb_in : pb_lat);
        ADDR_C:  bus_rdata = pc_rd;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R3: a mode definition leaves both port latches at zero
  a_r3_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> pa_out == '0 && pb_out == '0);

  // R5: a single-bit operation touches at most one port C latch bit
  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $countones(pc_lat ^ $past(pc_lat)) <= 1);
endmodule

// File: tb/test_ppi_top.sv
module test_ppi_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'hFF, pb_in = 8'hFF, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ppi_top i_ppi_top (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // simple-mode vectors: {control word, written value, pin value}
  localparam logic [23:0] VECS [6] = '{
    24'h805AC3, 24'h9B0F96, 24'h91E718, 24'h8A3CA5, 24'h83697E, 24'h98F04D
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    pa_in = 8'h6B;
    rd(2'd0, d); chk("R1 read A is pins", d, 8'h6B);
    rd(2'd3, d); chk("R2 control read", d, 8'h00);
    pa_in = 8'hFF;

    // R4 simple mode table
    for (int i = 0; i < 6; i++) begin
      logic [7:0] c, w, p, cm;
      c = VECS[i][23:16]; w = VECS[i][15:8]; p = VECS[i][7:0];
      cm = {{4{c[3]}}, {4{c[0]}}};
      wr(2'd3, c);
      pa_in = p; pb_in = p; pc_in = p;
      wr(2'd0, w); wr(2'd1, w); wr(2'd2, w);
      chk("R4 pa_oe", pa_oe, c[4] ? 8'h00 : 8'hFF);
      chk("R4 pb_oe", pb_oe, c[1] ? 8'h00 : 8'hFF);
      chk("R4 pc_oe", pc_oe, ~cm);
      chk("R4 pa_out", pa_out, w);
      rd(2'd0, d); chk("R4 read A", d, c[4] ? p : w);
      rd(2'd1, d); chk("R4 read B", d, c[1] ? p : w);
      rd(2'd2, d); chk("R4 read C", d, (p & cm) | (w & ~cm));
    end
    pa_in = 8'hFF; pb_in = 8'hFF; pc_in = 8'hFF;

    // R3 mode write clears latches
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h5A); wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    wr(2'd3, 8'h80);
    chk("R3 A latch cleared", pa_out, 8'h00);
    chk("R3 B latch cleared", pb_out, 8'h00);
    chk("R3 C latch cleared", pc_out, 8'h00);

    // R5 single-bit set/reset
    wr(2'd3, 8'h0B); chk("R5 set bit5", pc_out, 8'h20);
    wr(2'd3, 8'h01); chk("R5 set bit0", pc_out, 8'h21);
    wr(2'd3, 8'h0A); chk("R5 clear bit5", pc_out, 8'h01);

    // R6 R7 R8 R10 R12 strobed input on port A
    wr(2'd3, 8'hB0);
    chk("R10 pc_oe strobed in A", pc_oe, 8'hEF);
    wr(2'd3, 8'h09);
    pa_in = 8'hC3; pc_in[4] = 1'b0; tick();
    chk("R6 ibf set", {7'd0, pc_out[5]}, 8'd1);
    chk("R7 no intr while strobe low", {7'd0, pc_out[3]}, 8'd0);
    pa_in = 8'h11; pc_in[4] = 1'b1; tick();
    chk("R7 intr after strobe rise", {7'd0, pc_out[3]}, 8'd1);
    pa_in = 8'h77; pc_in[4] = 1'b0; tick();
    pc_in[4] = 1'b1; tick();
    chk("R8 ibf held", {7'd0, pc_out[5]}, 8'd1);
    rd(2'd2, d); chk("R12 status read", d, 8'h38);
    rd(2'd0, d); chk("R8 refused strobe kept byte", d, 8'hC3);
    chk("R7 ibf cleared by read", {7'd0, pc_out[5]}, 8'd0);
    chk("R7 intr cleared by read", {7'd0, pc_out[3]}, 8'd0);

    // R9 R10 strobed output on port B
    wr(2'd3, 8'h84);
    chk("R10 pc_oe strobed out B", pc_oe, 8'hFB);
    chk("R9 obf idle high", {7'd0, pc_out[1]}, 8'd1);
    wr(2'd3, 8'h05);
    wr(2'd1, 8'hA5);
    chk("R9 pb_out", pb_out, 8'hA5);
    chk("R9 pb_oe", pb_oe, 8'hFF);
    chk("R9 obf low", {7'd0, pc_out[1]}, 8'd0);
    pc_in[2] = 1'b0; tick();
    chk("R9 obf high on ack", {7'd0, pc_out[1]}, 8'd1);
    chk("R9 no intr while ack low", {7'd0, pc_out[0]}, 8'd0);
    pc_in[2] = 1'b1; tick();
    chk("R9 intr after ack", {7'd0, pc_out[0]}, 8'd1);
    wr(2'd1, 8'h5A);
    chk("R9 write clears intr", {7'd0, pc_out[0]}, 8'd0);

    // R11 bidirectional port A
    wr(2'd3, 8'hC0);
    wr(2'd3, 8'h09); wr(2'd3, 8'h0D);
    chk("R11 oe off while ack high", pa_oe, 8'h00);
    wr(2'd0, 8'h3C);
    chk("R11 obf low", {7'd0, pc_out[7]}, 8'd0);
    pc_in[6] = 1'b0; #1;
    chk("R11 oe on during ack", pa_oe, 8'hFF);
    chk("R11 drives byte", pa_out, 8'h3C);
    tick();
    pc_in[6] = 1'b1; tick();
    chk("R11 obf high", {7'd0, pc_out[7]}, 8'd1);
    chk("R11 intr from output side", {7'd0, pc_out[3]}, 8'd1);
    chk("R11 oe off after ack", pa_oe, 8'h00);
    pa_in = 8'h5E; pc_in[4] = 1'b0; tick();
    pc_in[4] = 1'b1; tick();
    chk("R11 ibf set", {7'd0, pc_out[5]}, 8'd1);
    rd(2'd0, d); chk("R11 read captured", d, 8'h5E);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule